// File: doc/BRIEF.md
# Atomic Fetch-and-Op Memory Unit

This block sits on the memory side of an interconnect and performs indivisible read-modify-write operations on a small local store. The store holds one 64-bit operand word for each 64-byte unit. A request carries a load/store flag, an address and store data. The operation is not carried in an opcode field. It is taken from three low address bits, and the same three bits mean different operations for a load and for a store. Loads return the word as it was before any update. Stores return a response beat that carries no data, so a requester can count completions.

Each request runs through a fixed controller sequence. The states are `ST_IDLE` (accept), `ST_READ` (issue the synchronous read), `ST_MODIFY` (compute the new word) and `ST_WRITE` (write back and respond). The transitions are: `ST_IDLE -> ST_READ` when a request is accepted, `ST_IDLE -> ST_IDLE` when no request is offered, `ST_READ -> ST_MODIFY`, `ST_MODIFY -> ST_WRITE` and `ST_WRITE -> ST_IDLE`, each taken unconditionally. The block accepts a new request only in `ST_IDLE`. A following request to the same unit therefore always sees the completed write-back of the one before it, and responses leave in request order.

Top module: `fop_unit`

## Requirements
- R1: While reset is asserted and right after it, `req_ready` is 1 and `rsp_valid` is 0. Every unit of the store reads as zero after reset.
- R2: Address bits [9:6] select one of 16 units and bits [5:3] select the operation. Bits [2:0] and bits [39:10] are ignored, so addresses that differ only there reach the same word.
- R3: Load encodings of bits [5:3]: 000 returns the word unchanged; 001 returns it and then adds one; 010 returns it and then subtracts one; 011 returns it and then clears it to zero. The returned data is always the value before the update.
- R4: Store encodings of bits [5:3]: 000 replaces the word with the store data; 001 adds one; 010 subtracts one; 011 ANDs the word with the store data; 100 ORs the word with the store data.
- R5: A store produces exactly one response beat with `rsp_data` = 0 and `rsp_err` = 0.
- R6: Increment and decrement wrap modulo 2^64: all-ones plus one gives zero, and zero minus one gives all-ones, with no flag.
- R7: Load encodings 100 to 111 and store encodings 101 to 111 produce a response with `rsp_err` = 1 and `rsp_data` = 0, and leave the store unchanged.
- R8: A request accepted at clock edge A produces `rsp_valid` for exactly the one cycle that follows edge A+2. `req_ready` is 0 from edge A until edge A+3.
- R9: Requests complete one at a time in acceptance order. A request to a unit sees the full effect of every earlier request, including back-to-back requests to the same unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block accepts the request in this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 40 | Byte address: unit index and operation code |
| req_wdata | input | 64 | Store data for the write, AND and OR operations |
| rsp_valid | output | 1 | One-cycle response beat |
| rsp_data | output | 64 | Old word for a good load, zero otherwise |
| rsp_err | output | 1 | Unsupported encoding, memory unchanged |

## Verification
The bench targets the places where a load and a store share the same code bits. A decoder that ignored the load/store flag would turn a fetch-and-clear into an AND, or a store OR into an error. Returning the updated word instead of the old one would show up on every fetch-and-increment. The bench checks the wrap points at zero and all-ones, and a design that saturated or flagged there would miscompare. It also checks that unsupported codes leave the word intact, which catches a design that writes back garbage. Back-to-back increments to one unit, and aliasing through the ignored address bits, expose a lost update or a wrong index slice as a wrong count.

// File: rtl/fop_pkg.sv
package fop_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_MODIFY,
        ST_WRITE
    } fop_state_e;

    typedef enum logic [3:0] {
        K_READ,
        K_FINC,
        K_FDEC,
        K_FCLR,
        K_WRITE,
        K_INC,
        K_DEC,
        K_AND,
        K_OR,
        K_BAD
    } fop_kind_e;

endpackage

// File: rtl/fop_decode.sv
module fop_decode
    import fop_pkg::*;
(
    input  logic       is_store,
    input  logic [2:0] code,
    output fop_kind_e  kind,
    output logic       writes,
    output logic       bad
);
    always_comb begin
        kind = K_BAD;
        if (is_store) begin
            unique case (code)
                3'b000:  kind = K_WRITE;
                3'b001:  kind = K_INC;
                3'b010:  kind = K_DEC;
                3'b011:  kind = K_AND;
                3'b100:  kind = K_OR;
                default: kind = K_BAD;
            endcase
        end else begin
            unique case (code)
                3'b000:  kind = K_READ;
                3'b001:  kind = K_FINC;
                3'b010:  kind = K_FDEC;
                3'b011:  kind = K_FCLR;
                default: kind = K_BAD;
            endcase
        end
        bad    = (kind == K_BAD);
        writes = !(kind == K_BAD || kind == K_READ);
    end
endmodule

// File: rtl/fop_alu.sv
module fop_alu
    import fop_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  fop_kind_e         kind,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] new_val
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    always_comb begin
        unique case (kind)
            K_FINC, K_INC: new_val = old_val + ONE;
            K_FDEC, K_DEC: new_val = old_val - ONE;
            K_FCLR:        new_val = '0;
            K_WRITE:       new_val = operand;
            K_AND:         new_val = old_val & operand;
            K_OR:          new_val = old_val | operand;
            default:       new_val = old_val;
        endcase
    end
endmodule

// File: rtl/fop_store.sv
module fop_store #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
            rd_data <= '0;
        end else begin
            if (wr_en) words[wr_idx] <= wr_data;
            if (rd_en) rd_data <= words[rd_idx];
        end
    end
endmodule

// File: rtl/fop_ctrl.sv
module fop_ctrl
    import fop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output fop_state_e state,
    output logic       accept,
    output logic       rd_en,
    output logic       mod_en,
    output logic       wb_en
);
    fop_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req_valid) nxt = ST_READ;
            ST_READ:   nxt = ST_MODIFY;
            ST_MODIFY: nxt = ST_WRITE;
            ST_WRITE:  nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        accept = (state == ST_IDLE) && req_valid;
        rd_en  = (state == ST_READ);
        mod_en = (state == ST_MODIFY);
        wb_en  = (state == ST_WRITE);
    end
endmodule

// File: rtl/fop_unit.sv
module fop_unit
    import fop_pkg::*;
#(
    parameter int ADDR_W   = 40,
    parameter int DATA_W   = 64,
    parameter int IDX_W    = 4,
    parameter int UNIT_LSB = 6,
    parameter int CODE_LSB = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_store,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_err
);
    localparam int IDX_HI = UNIT_LSB + IDX_W - 1;

    fop_state_e        state;
    logic              accept, rd_en, mod_en, wb_en;
    logic              store_q;
    logic [IDX_W-1:0]  idx_q;
    logic [2:0]        code_q;
    logic [DATA_W-1:0] operand_q, old_q, new_q, rd_data, alu_out;
    fop_kind_e         kind;
    logic              writes, bad;
    logic              mem_we;
    logic              unused_addr_bits;

    assign unused_addr_bits = ^{req_addr[ADDR_W-1:IDX_HI+1], req_addr[CODE_LSB-1:0]};

    fop_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .state(state),
        .accept(accept), .rd_en(rd_en), .mod_en(mod_en), .wb_en(wb_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q   <= 1'b0;
            idx_q     <= '0;
            code_q    <= '0;
            operand_q <= '0;
        end else if (accept) begin
            store_q   <= req_is_store;
            idx_q     <= req_addr[IDX_HI:UNIT_LSB];
            code_q    <= req_addr[CODE_LSB+2:CODE_LSB];
            operand_q <= req_wdata;
        end
    end

    fop_decode u_dec (
        .is_store(store_q), .code(code_q), .kind(kind), .writes(writes), .bad(bad)
    );

    fop_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(idx_q), .rd_data(rd_data),
        .wr_en(mem_we), .wr_idx(idx_q), .wr_data(new_q)
    );

    fop_alu #(.DATA_W(DATA_W)) u_alu (
        .kind(kind), .old_val(rd_data), .operand(operand_q), .new_val(alu_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            old_q <= '0;
            new_q <= '0;
        end else if (mod_en) begin
            old_q <= rd_data;
            new_q <= alu_out;
        end
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        mem_we    = wb_en && writes;
        rsp_valid = wb_en;
        rsp_err   = wb_en && bad;
        rsp_data  = (wb_en && !store_q && !bad) ? old_q : '0;
    end
endmodule

// File: rtl/fop_unit_chk.sv
module fop_unit_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_is_store,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_err,
    input logic              mem_we
);
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |-> (req_ready && !rsp_valid));

    a_r8_rsp_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ##3 rsp_valid);

    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r8_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r5_store_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_is_store) |-> ##3 (rsp_data == '0));

    a_r7_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_data == '0));

    a_r7_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !mem_we);
endmodule

bind fop_unit fop_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_store(req_is_store), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .mem_we(mem_we)
);

// File: tb/fop_unit_tb.sv
module fop_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_is_store = 1'b0;
    logic [39:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [63:0] rsp_data;

    always #5 clk = ~clk;

    fop_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_is_store(req_is_store), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
    );

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    int busy_from = -10;
    int busy_to = -10;
    logic [63:0] model [16];

    int          q_due [$];
    logic [63:0] q_data [$];
    logic        q_err [$];
    string       q_tag [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic fail_line(string tag, string what, logic [63:0] act, logic [63:0] exp);
        miscompares++;
        $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    endtask

    // Reference compare on every falling edge once out of reset
    always @(negedge clk) begin
        if (rst_n) begin
            logic exp_valid;
            logic exp_ready;
            exp_valid = (q_due.size() > 0) && (q_due[0] == cyc);
            exp_ready = !(cyc >= busy_from && cyc <= busy_to);
            vectors++;
            if (rsp_valid !== exp_valid)
                fail_line(exp_valid ? q_tag[0] : "R8", "rsp_valid", 64'(rsp_valid), 64'(exp_valid));
            if (req_ready !== exp_ready)
                fail_line("R8", "req_ready", 64'(req_ready), 64'(exp_ready));
            if (exp_valid) begin
                vectors++;
                if (rsp_data !== q_data[0]) fail_line(q_tag[0], "rsp_data", rsp_data, q_data[0]);
                if (rsp_err !== q_err[0])   fail_line(q_tag[0], "rsp_err", 64'(rsp_err), 64'(q_err[0]));
                void'(q_due.pop_front());
                void'(q_data.pop_front());
                void'(q_err.pop_front());
                void'(q_tag.pop_front());
            end
        end
    end

    // Called at a falling edge; returns at a falling edge
    task automatic send(input logic st, input logic [39:0] addr, input logic [63:0] wd,
                        input string tag);
        int          idx;
        logic [2:0]  code;
        logic [63:0] old;
        logic [63:0] nv;
        logic        err;
        logic [63:0] rd;
        req_valid    = 1'b1;
        req_is_store = st;
        req_addr     = addr;
        req_wdata    = wd;
        while (!req_ready) @(negedge clk);
        idx  = int'(addr[9:6]);
        code = addr[5:3];
        old  = model[idx];
        nv   = old;
        err  = 1'b0;
        rd   = 64'd0;
        if (st) begin
            case (code)
                3'b000: nv = wd;
                3'b001: nv = old + 64'd1;
                3'b010: nv = old - 64'd1;
                3'b011: nv = old & wd;
                3'b100: nv = old | wd;
                default: err = 1'b1;
            endcase
        end else begin
            case (code)
                3'b000: nv = old;
                3'b001: nv = old + 64'd1;
                3'b010: nv = old - 64'd1;
                3'b011: nv = 64'd0;
                default: err = 1'b1;
            endcase
            if (!err) rd = old;
        end
        if (!err) model[idx] = nv;
        busy_from = cyc + 1;
        busy_to   = cyc + 3;
        q_due.push_back(cyc + 3);
        q_data.push_back(rd);
        q_err.push_back(err);
        q_tag.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [39:0] ad(int unit, logic [2:0] code);
        return {30'd0, 4'(unit), code, 3'b000};
    endfunction

    task automatic drain();
        while (q_due.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 64'd0;
        repeat (3) @(negedge clk);
        vectors++;
        if (req_ready !== 1'b1 || rsp_valid !== 1'b0)
            fail_line("R1", "reset outputs", {62'd0, req_ready, rsp_valid}, 64'h2);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: all units zero after reset
        for (int u = 0; u < 16; u++) send(1'b0, ad(u, 3'b000), 64'd0, "R1");
        drain();

        // R4 / R3: write then each load form, old value returned
        send(1'b1, ad(3, 3'b000), 64'h1234, "R4");
        send(1'b0, ad(3, 3'b000), 64'd0, "R3");
        send(1'b0, ad(3, 3'b001), 64'd0, "R3");
        send(1'b0, ad(3, 3'b000), 64'd0, "R3");
        send(1'b0, ad(3, 3'b010), 64'd0, "R3");
        send(1'b0, ad(3, 3'b011), 64'd0, "R3");
        send(1'b0, ad(3, 3'b000), 64'd0, "R3");

        // R4 / R5: store forms, no response data
        send(1'b1, ad(7, 3'b000), 64'hF0F0_00FF_1234_5678, "R5");
        send(1'b1, ad(7, 3'b001), 64'hDEAD, "R4");
        send(1'b1, ad(7, 3'b010), 64'hDEAD, "R4");
        send(1'b1, ad(7, 3'b011), 64'h0FF0_FFFF_0000_FFFF, "R4");
        send(1'b1, ad(7, 3'b100), 64'h8000_0000_0000_0001, "R4");
        send(1'b0, ad(7, 3'b000), 64'd0, "R4");

        // R6: wrap at both ends
        send(1'b1, ad(9, 3'b000), 64'hFFFF_FFFF_FFFF_FFFF, "R6");
        send(1'b1, ad(9, 3'b001), 64'd0, "R6");
        send(1'b0, ad(9, 3'b010), 64'd0, "R6");
        send(1'b0, ad(9, 3'b001), 64'd0, "R6");
        send(1'b0, ad(9, 3'b000), 64'd0, "R6");

        // R7: unsupported encodings leave the word intact
        send(1'b1, ad(5, 3'b000), 64'hABCD, "R7");
        for (int c = 4; c < 8; c++) send(1'b0, ad(5, 3'(c)), 64'd0, "R7");
        for (int c = 5; c < 8; c++) send(1'b1, ad(5, 3'(c)), 64'd0, "R7");
        send(1'b0, ad(5, 3'b000), 64'd0, "R7");

        // R2: ignored address bits alias to the same unit
        send(1'b1, {30'h2AAA_5555, 4'd11, 3'b000, 3'b111}, 64'h77, "R2");
        send(1'b0, {30'h0000_0001, 4'd11, 3'b001, 3'b101}, 64'd0, "R2");
        send(1'b0, ad(11, 3'b000), 64'd0, "R2");
        send(1'b0, ad(10, 3'b000), 64'd0, "R2");

        // R9: back-to-back updates to one unit
        for (int k = 0; k < 10; k++) send(1'b1, ad(2, 3'b001), 64'd0, "R9");
        for (int k = 0; k < 4; k++)  send(1'b0, ad(2, 3'b010), 64'd0, "R9");
        send(1'b0, ad(2, 3'b000), 64'd0, "R9");

        // R8: mixed traffic with gaps and random operations
        for (int k = 0; k < 300; k++) begin
            logic [39:0] a;
            a = {$urandom(), $urandom()} & 40'hFF_FFFF_FFFF;
            send(1'($urandom()), a, {$urandom(), $urandom()}, "R8");
            if (($urandom() % 4) == 0) repeat ($urandom() % 3) @(negedge clk);
        end
        drain();
        for (int u = 0; u < 16; u++) send(1'b0, ad(u, 3'b000), 64'd0, "R9");
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule